// File: doc/BRIEF.md
# Serial-Clocked Wiper Up/Down Stepper

This block handles the open-ended stepping phase of a dual digital potentiometer's serial control path. Once the command decoder has recognised and acknowledged the step instruction (opcode 0010, register bits 00, with the low bit picking the pot), it arms this block with the index of the chosen pot. From then on, every rising edge of the serial clock nudges that pot's 6-bit wiper code by one tap. The serial data level sampled at that edge gives the direction: high moves toward the high terminal (code plus one) and low moves toward the low terminal (code minus one). No acknowledge slots are inserted and no byte count applies. The stream runs until the bus STOP condition disarms the block.

The wiper registers themselves live outside this block. It reads their current codes and returns a per-pot write strobe with the new code. The strobe is combinational, so the register takes the new value on the same clock edge as the sampled serial clock rise. Codes saturate at 0 and 63. A step that would leave that range produces no strobe. Only the volatile wiper codes are touched. Non-volatile storage needs a separate transfer command and is handled elsewhere.

Top module: `wiper_stepper`

## Requirements
- R1: After reset the block is disarmed and `upd_en_o` is all zero.
- R2: A cycle with `arm_i` high and `stop_i` low arms the block from the next cycle and latches `arm_pot_i`. Changes of `arm_pot_i` while armed have no effect on which pot steps.
- R3: While armed, a cycle with `scl_rise_i` high and `sda_i` high asserts `upd_en_o` bit *p* for the latched pot *p* only, with `upd_code_o` equal to that pot's current code plus one, in the same cycle.
- R4: While armed, a cycle with `scl_rise_i` high and `sda_i` low asserts the strobe for pot *p* with `upd_code_o` equal to the current code minus one.
- R5: Codes saturate. An increment at 63 or a decrement at 0 gives no strobe, so the code never wraps.
- R6: `stop_i` disarms the block from the next cycle, and it wins over `arm_i` in the same cycle. Serial clock rises after that give no strobe.
- R7: A `scl_rise_i` while disarmed, including in the cycle `arm_i` is applied, gives no strobe.
- R8: The pot that was not selected is never strobed during a session.
- R9: Any mix of up and down steps in one session applies each step in order, with saturation at each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle strobe: step instruction accepted |
| arm_pot_i | input | 1 | Pot index to step, sampled with `arm_i` |
| stop_i | input | 1 | One-cycle strobe: bus STOP seen |
| scl_rise_i | input | 1 | One-cycle strobe: synchronised serial clock rising edge |
| sda_i | input | 1 | Synchronised serial data level |
| cur_codes_i | input | 12 | Current wiper codes, pot *i* at bits [6i+5:6i] |
| upd_en_o | output | 2 | Per-pot write strobe for the wiper register |
| upd_code_o | output | 6 | New code to write for the strobed pot |

## Verification
The hardest situations to reach are the saturation edges when stepping is interleaved: a direction reversal that lands exactly at 0 or 63, and a strobe that must stay silent while the code sits at a limit. The bench holds the wiper registers itself and feeds every strobe back, so the block always sees the current code. It drives long monotone runs well past both limits from several start codes on each pot, then a pseudo-random up/down stream. After each pulse it compares the strobe and code with an independently computed clamped step.

// File: rtl/wst_pkg.sv
package wst_pkg;
  // Clamped one-tap step; returns the code unchanged at a limit.
  function automatic int clamp_step(input int code, input bit up, input int top);
    int nxt;
    if (up) nxt = (code >= top) ? code : code + 1;
    else    nxt = (code <= 0)   ? code : code - 1;
    return nxt;
  endfunction

  // Width of an index that selects one of n items (at least 1).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wst_session.sv
module wst_session #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] arm_pot_i,
  input  logic             stop_i,
  output logic             armed_o,
  output logic [SEL_W-1:0] sel_o
);
  logic armed_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      sel_q   <= arm_pot_i;
    end
  end

  assign armed_o = armed_q;
  assign sel_o   = sel_q;

  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !armed_o); // R6
  AST_ARM_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !stop_i) |=> (armed_o && sel_o == $past(arm_pot_i))); // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !arm_i) |=> (sel_o == $past(sel_o))); // R2
endmodule

// File: rtl/wst_step_unit.sv
module wst_step_unit
  import wst_pkg::*;
#(
  parameter int NUM_POTS = 2,
  parameter int CODE_W   = 6,
  parameter int SEL_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire_i,
  input  logic                       up_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [NUM_POTS*CODE_W-1:0] cur_codes_i,
  output logic [NUM_POTS-1:0]        upd_en_o,
  output logic [CODE_W-1:0]          upd_code_o
);
  localparam int TOP = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] cur_sel;
  logic [CODE_W-1:0] nxt_code;
  logic              moved;

  always_comb begin
    cur_sel = '0;
    for (int i = 0; i < NUM_POTS; i++)
      if (sel_i == SEL_W'(i)) cur_sel = cur_codes_i[i*CODE_W +: CODE_W];
  end

  always_comb begin
    nxt_code = CODE_W'(clamp_step(int'(cur_sel), up_i, TOP));
    moved    = fire_i && (nxt_code != cur_sel);
  end

  generate
    for (genvar g = 0; g < NUM_POTS; g++) begin : g_strobe
      assign upd_en_o[g] = moved && (sel_i == SEL_W'(g));
    end
  endgenerate

  assign upd_code_o = nxt_code;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_en_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |-> (upd_en_o == '0)); // R7
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_o != '0) |-> (up_i ? (upd_code_o == cur_sel + 1'b1)
                               : (upd_code_o == cur_sel - 1'b1))); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && ((up_i && cur_sel == CODE_W'(TOP)) || (!up_i && cur_sel == '0)))
      |-> (upd_en_o == '0)); // R5
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wst_pkg::*;
#(
  parameter int NUM_POTS = 2,
  parameter int CODE_W   = 6,
  localparam int SEL_W   = idx_w(NUM_POTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm_i,
  input  logic [SEL_W-1:0]           arm_pot_i,
  input  logic                       stop_i,
  input  logic                       scl_rise_i,
  input  logic                       sda_i,
  input  logic [NUM_POTS*CODE_W-1:0] cur_codes_i,
  output logic [NUM_POTS-1:0]        upd_en_o,
  output logic [CODE_W-1:0]          upd_code_o
);
  logic             armed;
  logic [SEL_W-1:0] sel;
  logic             step_fire;

  wst_session #(.SEL_W(SEL_W)) u_session (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .arm_pot_i(arm_pot_i),
    .stop_i(stop_i), .armed_o(armed), .sel_o(sel)
  );

  assign step_fire = armed && scl_rise_i;

  wst_step_unit #(.NUM_POTS(NUM_POTS), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_step (
    .clk(clk), .rst_n(rst_n), .fire_i(step_fire), .up_i(sda_i), .sel_i(sel),
    .cur_codes_i(cur_codes_i), .upd_en_o(upd_en_o), .upd_code_o(upd_code_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (upd_en_o == '0)); // R1
  AST_LATE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i) |-> (upd_en_o == '0)); // R6
endmodule

// File: tb/wiper_stepper_test.sv
module wiper_stepper_test;
  localparam int NP = 2, CW = 6, TOPV = 63;

  logic clk = 0, rst_n = 0;
  logic arm = 0, arm_pot = 0, stop = 0, scl_rise = 0, sda = 0;
  logic [NP*CW-1:0] cur;
  logic [NP-1:0] upd_en;
  logic [CW-1:0] upd_code;
  int w [NP];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_stepper uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .arm_pot_i(arm_pot), .stop_i(stop),
    .scl_rise_i(scl_rise), .sda_i(sda), .cur_codes_i(cur),
    .upd_en_o(upd_en), .upd_code_o(upd_code)
  );

  always_comb for (int i = 0; i < NP; i++) cur[i*CW +: CW] = CW'(w[i]);

  always @(posedge clk)
    for (int i = 0; i < NP; i++) if (upd_en[i]) w[i] = int'(upd_code);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One serial clock rise; expected result computed from requirement text.
  task automatic pulse(input bit up, input bit live, input int p, input string tag);
    int was, want, en_exp;
    @(negedge clk);
    scl_rise = 1; sda = up; #1;
    was = w[p];
    if (up) want = (was == TOPV) ? was : was + 1;
    else    want = (was == 0) ? was : was - 1;
    en_exp = (live && want != was) ? (1 << p) : 0;
    chk(int'(upd_en) == en_exp, tag, int'(upd_en), en_exp);
    if (en_exp != 0) chk(int'(upd_code) == want, tag, int'(upd_code), want);
    @(negedge clk);
    scl_rise = 0;
  endtask

  task automatic do_arm(input int p);
    @(negedge clk); arm = 1; arm_pot = p[0];
    @(negedge clk); arm = 0; arm_pot = ~p[0];
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int other;
    w[0] = 10; w[1] = 40;
    repeat (3) @(negedge clk);
    chk(upd_en == 0, "R1 reset", int'(upd_en), 0);
    rst_n = 1;
    pulse(1, 0, 0, "R7 idle rise");
    pulse(0, 0, 1, "R7 idle rise");

    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 3; s++) begin
        w[0] = 5 + 25 * s; w[1] = 58 - 25 * s;
        other = w[1 - p];
        do_arm(p);
        for (int k = 0; k < 66; k++) pulse(1, 1, p, "R3/R5 up run");
        chk(w[p] == TOPV, "R5 top clamp", w[p], TOPV);
        for (int k = 0; k < 70; k++) pulse(0, 1, p, "R4/R5 down run");
        chk(w[p] == 0, "R5 bottom clamp", w[p], 0);
        lfsr = 8'h5A + 8'(s);
        for (int k = 0; k < 50; k++) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          pulse(lfsr[0], 1, p, "R9 mixed");
        end
        chk(w[1 - p] == other, "R8 other pot", w[1 - p], other);
        do_stop();
        pulse(1, 0, p, "R6 after stop");
        pulse(0, 0, p, "R6 after stop");
      end
    end

    // arm and serial rise in the same cycle: rise ignored
    w[0] = 20; w[1] = 20;
    @(negedge clk); arm = 1; arm_pot = 0; scl_rise = 1; sda = 1; #1;
    chk(upd_en == 0, "R7 rise with arm", int'(upd_en), 0);
    @(negedge clk); arm = 0; scl_rise = 0;
    pulse(1, 1, 0, "R2 armed after strobe");
    do_stop();

    // stop wins over arm
    @(negedge clk); arm = 1; stop = 1; arm_pot = 1;
    @(negedge clk); arm = 0; stop = 0;
    pulse(1, 0, 1, "R6 stop beats arm");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule